// File: doc/BRIEF.md
# Mixed-Width Dual-Clock Block RAM

This block is a synchronous memory with two independent ports, A and B. Each port has its own clock, clock enable, synchronous reset, write enable, chip-select code, address, write data and read data. Both ports see the same bit array, but each port can use its own word width. The array holds a fixed number of bits. A port with a wider word therefore has fewer addresses. Word `a` of a port whose width is `W` occupies array bits `a*W` through `a*W+W-1`, with the word's LSB at the lower bit. Data written through one port can be read back through the other at the other port's width.

An access happens on a port's clock edge when three conditions hold:
- the clock enable is high,
- reset is low,
- the 3-bit chip-select input equals that port's configured code.

On that edge the address and write data are taken into the array, and the array's previous contents at that address are latched as read data. A per-port parameter adds a second output register, which adds one cycle of read latency. The array starts from a parameter image. A parameter can also disable all writes, so the block acts as a ROM holding that image.

Top module: `mwram_dp`

## Requirements
- R1: A port's reset makes its read data zero after the reset edge, with or without the output register. Reset leaves the array contents unchanged.
- R2: After start-up, every word read returns the preload image. Word `a` of a `W`-bit port reads image bits `a*W` .. `a*W+W-1`.
- R3: Narrow words written through the narrow port A (8 bits) can be read through the wide port B (32 bits). B word `b` is made of A words `4b` .. `4b+3`, with A word `4b` in bits 7:0 and A word `4b+3` in bits 31:24.
- R4: A 32-bit word written through port B reads back through port A as four bytes. The least significant byte is at the lowest A address.
- R5: Without the output register (port A), read data is valid after the access edge. With the output register (port B), the value after the access edge is the previous read data, and the new data appears one edge later with the clock enable held high.
- R6: While a port's clock enable is low, that port's write has no effect on the array and its read data holds.
- R7: An access whose chip-select input differs from the port's code neither writes nor updates read data. In the bench, port A's code is 2 and port B's code is 5.
- R8: A write on a port returns the word's previous contents on that same port's read data for that access (read before write).
- R9: With writes disabled (ROM mode), write attempts leave the preload image intact and reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| ce_a | input | 1 | Port A clock enable |
| rst_a | input | 1 | Port A synchronous reset of read data, active high |
| we_a | input | 1 | Port A write enable |
| sel_a | input | 3 | Port A chip-select code |
| addr_a | input | log2(BITS/W_A) | Port A word address |
| din_a | input | W_A | Port A write data |
| dout_a | output | W_A | Port A read data |
| clk_b | input | 1 | Port B clock |
| ce_b | input | 1 | Port B clock enable |
| rst_b | input | 1 | Port B synchronous reset of read data, active high |
| we_b | input | 1 | Port B write enable |
| sel_b | input | 3 | Port B chip-select code |
| addr_b | input | log2(BITS/W_B) | Port B word address |
| din_b | input | W_B | Port B write data |
| dout_b | output | W_B | Port B read data |

## Verification
The assertions assume that reset is held from time zero until both ports have seen a clock edge. They also assume that the two ports never write overlapping bits on the same edge, since that result is undefined. The stimulus drives both ports from one bench clock and runs one port's accesses at a time, so no same-edge overlap can occur. The bench changes inputs on the falling edge and reads outputs one falling edge after the edge that should have updated them. The port with the output register is read one extra edge later, with its enable held.

// File: rtl/mwram_pkg.sv
package mwram_pkg;
  localparam int MW_SEL_W = 3;
  typedef logic [MW_SEL_W-1:0] mw_sel_t;
endpackage

// File: rtl/mwram_bank.sv
// One storage bank, written only from a single clock domain.
// The flat image is exposed so that both ports can combine the two banks.
module mwram_bank #(
  parameter int W = 8,
  parameter int BITS = 512,
  parameter logic [BITS-1:0] INIT = '0,
  localparam int AW = $clog2(BITS / W)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [W-1:0]    wdata,
  output logic [BITS-1:0] flat
);
  logic [BITS-1:0] mem = INIT;

  always_ff @(posedge clk) begin
    if (we) mem[int'(addr) * W +: W] <= wdata;
  end

  assign flat = mem;
endmodule

// File: rtl/mwram_port.sv
// Port control: chip-select decode, read latch, optional output register.
// The stored value of a bit is the XOR of the two banks, so the write data
// is pre-mixed with the other bank's current contents.
module mwram_port
  import mwram_pkg::*;
#(
  parameter int W = 8,
  parameter int BITS = 512,
  parameter mw_sel_t SEL = '0,
  parameter bit OREG = 1'b0,
  parameter bit WRITABLE = 1'b1,
  localparam int AW = $clog2(BITS / W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic            we,
  input  mw_sel_t         sel,
  input  logic [AW-1:0]   addr,
  input  logic [W-1:0]    din,
  input  logic [BITS-1:0] own_flat,
  input  logic [BITS-1:0] other_flat,
  output logic            bank_we,
  output logic [AW-1:0]   bank_addr,
  output logic [W-1:0]    bank_wdata,
  output logic [W-1:0]    dout
);
  logic         hit;
  logic [W-1:0] own_word;
  logic [W-1:0] other_word;
  logic [W-1:0] rd_q;

  assign hit        = ce && !rst && (sel == SEL);
  assign own_word   = own_flat[int'(addr) * W +: W];
  assign other_word = other_flat[int'(addr) * W +: W];

  assign bank_we    = hit && we && WRITABLE;
  assign bank_addr  = addr;
  assign bank_wdata = din ^ other_word;

  // Read latch: captures the pre-write word on the access edge.
  always_ff @(posedge clk) begin
    if (rst)      rd_q <= '0;
    else if (hit) rd_q <= own_word ^ other_word;
  end

  generate
    if (OREG) begin : g_oreg
      logic [W-1:0] out_q;
      always_ff @(posedge clk) begin
        if (rst)     out_q <= '0;
        else if (ce) out_q <= rd_q;
      end
      assign dout = out_q;
    end else begin : g_direct
      assign dout = rd_q;
    end
  endgenerate
endmodule

// File: rtl/mwram_dp.sv
module mwram_dp #(
  parameter int W_A = 8,
  parameter int W_B = 32,
  parameter int BITS = 512,
  parameter logic [2:0] SEL_A = 3'd0,
  parameter logic [2:0] SEL_B = 3'd0,
  parameter bit OREG_A = 1'b0,
  parameter bit OREG_B = 1'b1,
  parameter bit ROM_MODE = 1'b0,
  parameter logic [BITS-1:0] INIT = '0
) (
  input  logic                          clk_a,
  input  logic                          ce_a,
  input  logic                          rst_a,
  input  logic                          we_a,
  input  logic [2:0]                    sel_a,
  input  logic [$clog2(BITS/W_A)-1:0]   addr_a,
  input  logic [W_A-1:0]                din_a,
  output logic [W_A-1:0]                dout_a,
  input  logic                          clk_b,
  input  logic                          ce_b,
  input  logic                          rst_b,
  input  logic                          we_b,
  input  logic [2:0]                    sel_b,
  input  logic [$clog2(BITS/W_B)-1:0]   addr_b,
  input  logic [W_B-1:0]                din_b,
  output logic [W_B-1:0]                dout_b
);
  localparam int AW_A = $clog2(BITS / W_A);
  localparam int AW_B = $clog2(BITS / W_B);
  localparam bit WRITABLE = !ROM_MODE;

  logic [BITS-1:0] flat_a;
  logic [BITS-1:0] flat_b;
  logic            bwe_a, bwe_b;
  logic [AW_A-1:0] baddr_a;
  logic [AW_B-1:0] baddr_b;
  logic [W_A-1:0]  bdata_a;
  logic [W_B-1:0]  bdata_b;

  mwram_port #(.W(W_A), .BITS(BITS), .SEL(SEL_A), .OREG(OREG_A),
               .WRITABLE(WRITABLE)) u_port_a (
    .clk(clk_a), .rst(rst_a), .ce(ce_a), .we(we_a), .sel(sel_a),
    .addr(addr_a), .din(din_a), .own_flat(flat_a), .other_flat(flat_b),
    .bank_we(bwe_a), .bank_addr(baddr_a), .bank_wdata(bdata_a),
    .dout(dout_a));

  mwram_port #(.W(W_B), .BITS(BITS), .SEL(SEL_B), .OREG(OREG_B),
               .WRITABLE(WRITABLE)) u_port_b (
    .clk(clk_b), .rst(rst_b), .ce(ce_b), .we(we_b), .sel(sel_b),
    .addr(addr_b), .din(din_b), .own_flat(flat_b), .other_flat(flat_a),
    .bank_we(bwe_b), .bank_addr(baddr_b), .bank_wdata(bdata_b),
    .dout(dout_b));

  // Bank A carries the preload image, bank B starts at zero.
  mwram_bank #(.W(W_A), .BITS(BITS), .INIT(INIT)) u_bank_a (
    .clk(clk_a), .we(bwe_a), .addr(baddr_a), .wdata(bdata_a), .flat(flat_a));

  mwram_bank #(.W(W_B), .BITS(BITS), .INIT('0)) u_bank_b (
    .clk(clk_b), .we(bwe_b), .addr(baddr_b), .wdata(bdata_b), .flat(flat_b));
endmodule

// File: rtl/mwram_dp_chk.sv
module mwram_dp_chk #(
  parameter int W_A = 8,
  parameter int W_B = 32,
  parameter logic [2:0] SEL_A = 3'd0,
  parameter logic [2:0] SEL_B = 3'd0,
  parameter bit OREG_A = 1'b0,
  parameter bit OREG_B = 1'b1
) (
  input logic           clk_a,
  input logic           ce_a,
  input logic           rst_a,
  input logic [2:0]     sel_a,
  input logic [W_A-1:0] dout_a,
  input logic           clk_b,
  input logic           ce_b,
  input logic           rst_b,
  input logic [2:0]     sel_b,
  input logic [W_B-1:0] dout_b
);
  AST_RST_ZERO_A: assert property (@(posedge clk_a)
    rst_a |=> (dout_a == '0)); // R1
  AST_RST_ZERO_B: assert property (@(posedge clk_b)
    rst_b |=> (dout_b == '0)); // R1
  AST_CE_HOLD_A: assert property (@(posedge clk_a) disable iff (rst_a)
    !ce_a |=> $stable(dout_a)); // R6
  AST_CE_HOLD_B: assert property (@(posedge clk_b) disable iff (rst_b)
    !ce_b |=> $stable(dout_b)); // R6
  AST_SEL_MISS_A: assert property (@(posedge clk_a) disable iff (rst_a)
    (!OREG_A && ce_a && sel_a != SEL_A) |=> $stable(dout_a)); // R7
  AST_SEL_MISS_B: assert property (@(posedge clk_b) disable iff (rst_b)
    (!OREG_B && ce_b && sel_b != SEL_B) |=> $stable(dout_b)); // R7
endmodule

bind mwram_dp mwram_dp_chk #(
  .W_A(W_A), .W_B(W_B), .SEL_A(SEL_A), .SEL_B(SEL_B),
  .OREG_A(OREG_A), .OREG_B(OREG_B)
) u_chk (
  .clk_a(clk_a), .ce_a(ce_a), .rst_a(rst_a), .sel_a(sel_a), .dout_a(dout_a),
  .clk_b(clk_b), .ce_b(ce_b), .rst_b(rst_b), .sel_b(sel_b), .dout_b(dout_b)
);

// File: tb/mwram_dp_bench.sv
module mwram_dp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BITS = 512;
  localparam logic [2:0] SA = 3'd2;
  localparam logic [2:0] SB = 3'd5;

  function automatic logic [BITS-1:0] make_image();
    logic [BITS-1:0] v;
    for (int i = 0; i < BITS / 8; i++) v[i*8 +: 8] = 8'((i * 37 + 5) % 256);
    return v;
  endfunction
  localparam logic [BITS-1:0] IMG = make_image();

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic ce_a = 0, rst_a = 1, we_a = 0; logic [2:0] sel_a = SA;
  logic [5:0] addr_a = '0; logic [7:0] din_a = '0; logic [7:0] dout_a;
  logic ce_b = 0, rst_b = 1, we_b = 0; logic [2:0] sel_b = SB;
  logic [3:0] addr_b = '0; logic [31:0] din_b = '0; logic [31:0] dout_b;

  logic r_ce = 0, r_rst = 1, r_we = 0; logic [5:0] r_addr = '0;
  logic [7:0] r_din = '0; logic [7:0] r_dout; logic [31:0] r_doutb;

  mwram_dp #(.W_A(8), .W_B(32), .BITS(BITS), .SEL_A(SA), .SEL_B(SB),
             .OREG_A(1'b0), .OREG_B(1'b1), .ROM_MODE(1'b0), .INIT(IMG)) u_mwram_dp (
    .clk_a(clk), .ce_a(ce_a), .rst_a(rst_a), .we_a(we_a), .sel_a(sel_a),
    .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
    .clk_b(clk), .ce_b(ce_b), .rst_b(rst_b), .we_b(we_b), .sel_b(sel_b),
    .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b));

  mwram_dp #(.W_A(8), .W_B(32), .BITS(BITS), .SEL_A(3'd0), .SEL_B(3'd0),
             .OREG_A(1'b0), .OREG_B(1'b1), .ROM_MODE(1'b1), .INIT(IMG)) u_mwram_dp_rom (
    .clk_a(clk), .ce_a(r_ce), .rst_a(r_rst), .we_a(r_we), .sel_a(3'd0),
    .addr_a(r_addr), .din_a(r_din), .dout_a(r_dout),
    .clk_b(clk), .ce_b(1'b0), .rst_b(r_rst), .we_b(1'b0), .sel_b(3'd0),
    .addr_b(4'd0), .din_b(32'd0), .dout_b(r_doutb));

  logic [BITS-1:0] model = IMG;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic a_write(logic [5:0] a, logic [7:0] d);
    @(negedge clk); ce_a = 1; we_a = 1; sel_a = SA; addr_a = a; din_a = d;
    @(posedge clk); @(negedge clk); ce_a = 0; we_a = 0;
    model[int'(a)*8 +: 8] = d;
  endtask

  task automatic a_read(logic [5:0] a, output logic [7:0] q);
    @(negedge clk); ce_a = 1; we_a = 0; sel_a = SA; addr_a = a;
    @(posedge clk); @(negedge clk); q = dout_a; ce_a = 0;
  endtask

  task automatic b_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk); ce_b = 1; we_b = 1; sel_b = SB; addr_b = a; din_b = d;
    @(posedge clk); @(negedge clk); ce_b = 0; we_b = 0;
    model[int'(a)*32 +: 32] = d;
  endtask

  task automatic b_read(logic [3:0] a, output logic [31:0] q);
    @(negedge clk); ce_b = 1; we_b = 0; sel_b = SB; addr_b = a;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    q = dout_b; ce_b = 0;
  endtask

  task automatic t_reset_state();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_a = 0; rst_b = 0; r_rst = 0;
    check("R1 reset dout_a", 32'(dout_a), 32'd0);
    check("R1 reset dout_b", dout_b, 32'd0);
  endtask

  task automatic t_preload();
    logic [7:0] q8; logic [31:0] q32;
    foreach (q8[i]) begin end
    for (int a = 0; a < 64; a += 21) begin
      a_read(6'(a), q8); check("R2 preload A", 32'(q8), 32'(IMG[a*8 +: 8]));
    end
    b_read(4'd0, q32); check("R2 preload B0", q32, IMG[31:0]);
    b_read(4'd15, q32); check("R2 preload B15", q32, IMG[511:480]);
  endtask

  task automatic t_narrow_to_wide();
    logic [31:0] q32;
    a_write(6'd4, 8'h11); a_write(6'd5, 8'h22);
    a_write(6'd6, 8'h33); a_write(6'd7, 8'h44);
    b_read(4'd1, q32); check("R3 narrow write wide read", q32, 32'h44332211);
  endtask

  task automatic t_wide_to_narrow();
    logic [7:0] q8;
    b_write(4'd5, 32'hDEADBEEF);
    a_read(6'd20, q8); check("R4 byte 20", 32'(q8), 32'hEF);
    a_read(6'd21, q8); check("R4 byte 21", 32'(q8), 32'hBE);
    a_read(6'd23, q8); check("R4 byte 23", 32'(q8), 32'hDE);
  endtask

  task automatic t_latency();
    logic [31:0] q32;
    b_read(4'd1, q32);
    @(negedge clk); ce_b = 1; addr_b = 4'd5;
    @(posedge clk); @(negedge clk);
    check("R5 oreg first edge old", dout_b, 32'h44332211);
    @(posedge clk); @(negedge clk);
    check("R5 oreg second edge new", dout_b, 32'hDEADBEEF);
    ce_b = 0;
    @(negedge clk); ce_a = 1; addr_a = 6'd22; sel_a = SA;
    @(posedge clk); @(negedge clk);
    check("R5 direct one edge", 32'(dout_a), 32'hAD);
    ce_a = 0;
  endtask

  task automatic t_ce_low();
    logic [7:0] v8, q8; logic [31:0] v32, q32;
    a_read(6'd10, v8);
    @(negedge clk); ce_a = 0; we_a = 1; addr_a = 6'd10; din_a = ~v8;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R6 A hold ce low", 32'(dout_a), 32'(v8));
    we_a = 0;
    a_read(6'd10, q8); check("R6 A no write ce low", 32'(q8), 32'(v8));
    b_read(4'd2, v32);
    @(negedge clk); ce_b = 0; we_b = 1; addr_b = 4'd2; din_b = ~v32;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R6 B hold ce low", dout_b, v32);
    we_b = 0;
    b_read(4'd2, q32); check("R6 B no write ce low", q32, v32);
  endtask

  task automatic t_sel_miss();
    logic [7:0] v8, q8; logic [31:0] v32, q32;
    a_read(6'd11, v8);
    @(negedge clk); ce_a = 1; we_a = 1; sel_a = SB; addr_a = 6'd12; din_a = ~v8;
    @(posedge clk); @(negedge clk);
    check("R7 A hold sel miss", 32'(dout_a), 32'(v8));
    ce_a = 0; we_a = 0; sel_a = SA;
    a_read(6'd12, q8); check("R7 A no write sel miss", 32'(q8), 32'(model[12*8 +: 8]));
    b_read(4'd3, v32);
    @(negedge clk); ce_b = 1; we_b = 1; sel_b = SA; addr_b = 4'd4; din_b = ~v32;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R7 B hold sel miss", dout_b, v32);
    ce_b = 0; we_b = 0; sel_b = SB;
    b_read(4'd4, q32); check("R7 B no write sel miss", q32, model[4*32 +: 32]);
  endtask

  task automatic t_read_before_write();
    logic [7:0] old8, q8;
    old8 = model[30*8 +: 8];
    @(negedge clk); ce_a = 1; we_a = 1; sel_a = SA; addr_a = 6'd30; din_a = 8'h5A;
    @(posedge clk); @(negedge clk);
    check("R8 old data on write", 32'(dout_a), 32'(old8));
    ce_a = 0; we_a = 0; model[30*8 +: 8] = 8'h5A;
    a_read(6'd30, q8); check("R8 new data after", 32'(q8), 32'h5A);
  endtask

  task automatic t_reset_keeps();
    logic [7:0] q8; logic [31:0] q32;
    a_write(6'd40, 8'h77);
    b_read(4'd3, q32);
    @(negedge clk); rst_a = 1; rst_b = 1;
    @(posedge clk); @(negedge clk); rst_a = 0; rst_b = 0;
    check("R1 mid reset dout_a", 32'(dout_a), 32'd0);
    check("R1 mid reset dout_b", dout_b, 32'd0);
    a_read(6'd40, q8); check("R1 array kept A", 32'(q8), 32'h77);
    b_read(4'd10, q32); check("R1 array kept B", q32, model[10*32 +: 32]);
  endtask

  task automatic t_rom();
    @(negedge clk); r_ce = 1; r_we = 1; r_addr = 6'd3; r_din = ~IMG[31:24];
    @(posedge clk); @(negedge clk); r_we = 0;
    @(posedge clk); @(negedge clk);
    check("R9 rom ignores write", 32'(r_dout), 32'(IMG[31:24]));
    r_addr = 6'd50;
    @(posedge clk); @(negedge clk);
    check("R9 rom read image", 32'(r_dout), 32'(IMG[50*8 +: 8]));
    r_ce = 0;
  endtask

  initial begin
    t_reset_state();
    t_preload();
    t_narrow_to_wide();
    t_wide_to_narrow();
    t_latency();
    t_ce_low();
    t_sel_miss();
    t_read_before_write();
    t_reset_keeps();
    t_rom();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule